// File: doc/BRIEF.md
# Idle-Locked Serial Descrambler

This block sits in a 100 Mbit/s receive path just after line decoding. It takes one scrambled bit per clock at 125 MHz and rebuilds the plain bit stream. It XORs each received bit with a keystream bit from a local 11-stage shift register that follows the polynomial x^11 + x^9 + 1. Other stages handle equalization, clock recovery, NRZI conversion and symbol alignment.

The far end sends idle as a steady stream of plain ones. While idle is on the line, each received bit is the inverted keystream bit. The block loads its shift register from inverted received bits and tests each new bit against the register's prediction. A run of consistent bits long enough to cover the burst length gives lock. Once locked, the register runs freely and produces the keystream with no further input.

While locked, a hold timer counts the bits. Runs of descrambled ones count as idle observations. Enough observations reload the timer to its full span. If the timer runs out first, lock is dropped and acquisition starts again from nothing. The default span is 90250 cycles (722 µs at 125 MHz).

Top module: `descram_lock`

## Requirements
- R1: During and after reset, with no bits yet processed, `locked_o`, `valid_o` and `data_o` are all 0.
- R2: While hunting, the block locks after ACQ_RUN (default 40) consecutive received bits. The first 11 of these load the register and are not tested. Each later bit must equal the inverse of (register bit 11 back XOR register bit 9 back). `locked_o` goes high on the clock edge that samples the last bit of the run.
- R3: A bit that fails this test while hunting restarts the run from zero. A new full run of ACQ_RUN bits, including 11 fresh loading bits, is then needed before lock.
- R4: Each bit sampled while locked appears on `data_o` one clock later as the received bit XOR the keystream bit. `valid_o` is high in the same cycle. With the far end correctly tracked, `data_o` equals the far end's plain bit.
- R5: A bit sampled while not locked gives `valid_o` = 0 and `data_o` = 0 one clock later.
- R6: Without a timer reload, lock lasts for exactly HOLD_CYC sampled bits. The edge that samples the HOLD_CYC-th bit after lock (or after the last reload) drops `locked_o`. That bit still gives a valid output.
- R7: An idle observation is IDLE_BITS (default 10) consecutive descrambled ones, counted without overlap. Any zero clears the partial run. The IDLE_NEED-th observation (default 1) reloads the timer to HOLD_CYC on the edge that samples its last bit, then the count of observations starts again. Fewer observations do not reload the timer.
- R8: After lock is lost, reacquisition needs a complete new run of ACQ_RUN bits. No register or run state carries over.
- R9: The hold timer starts at its full HOLD_CYC span on the edge that grants lock. Partial idle runs and observations seen before lock do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 125 MHz bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Scrambled received bit, one per clock |
| data_o | output | 1 | Descrambled bit, 0 when not valid |
| valid_o | output | 1 | `data_o` holds a descrambled bit |
| locked_o | output | 1 | Keystream is locked to the far end |

## Verification
The bench drives a model far-end scrambler and targets several corner cases:
- **Off-by-one in the acquisition run.** It checks that 39 bits do not lock and the 40th does. A design that miscounts locks one bit early or late.
- **Corrupted bit during acquisition.** It corrupts one bit partway through an idle run. A design that keeps counting would lock on stale, poisoned register contents.
- **Exact expiry.** It counts the exact number of locked bits until expiry after a reload and after a fresh lock. An off-by-one timer, or one that reloads on a single observation when two are required, drops lock a cycle late or not at all.
- **Broken idle run.** It splits a ten-ones run with a zero. A counter that does not clear on zero would see a false observation and keep lock too long.
- **Garbage data.** It checks that random data produces neither a spurious lock nor stray output while valid is low.

// File: rtl/descram_pkg.sv
package descram_pkg;
  localparam int unsigned LFSR_W = 11;
  localparam int unsigned TAP_HI = 11;
  localparam int unsigned TAP_LO = 9;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;
endpackage

// File: rtl/descram_lfsr.sv
module descram_lfsr #(
  parameter int unsigned W      = 11,
  parameter int unsigned TAP_HI = 11,
  parameter int unsigned TAP_LO = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_rx_i,
  input  logic rx_bit_i,
  output logic key_o
);
  logic [W-1:0] hist_q;

  // bit i holds the keystream value from i+1 bits back
  assign key_o = hist_q[TAP_HI-1] ^ hist_q[TAP_LO-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[W-2:0], load_rx_i ? ~rx_bit_i : key_o};
  end
endmodule

// File: rtl/descram_acq.sv
module descram_acq #(
  parameter int unsigned RUN  = 40,
  parameter int unsigned SEED = 11,
  localparam int unsigned RW  = $clog2(RUN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hunt_i,
  input  logic          match_i,
  output logic          lock_hit_o,
  output logic [RW-1:0] run_o
);
  localparam logic [RW-1:0] SEED_V = RW'(SEED);
  localparam logic [RW-1:0] LAST_V = RW'(RUN - 1);

  logic [RW-1:0] run_q;
  logic          seeded;

  initial begin
    if (RUN <= SEED) $error("acquisition run must exceed seed length");
  end

  assign seeded     = (run_q >= SEED_V);
  assign lock_hit_o = hunt_i && seeded && match_i && (run_q == LAST_V);
  assign run_o      = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (!hunt_i)             run_q <= '0;
    else if (lock_hit_o)          run_q <= '0;
    else if (!seeded || match_i)  run_q <= run_q + 1'b1;
    else                          run_q <= '0;
  end
endmodule

// File: rtl/descram_hold.sv
module descram_hold #(
  parameter int unsigned HOLD_CYC  = 90250,
  parameter int unsigned IDLE_BITS = 10,
  parameter int unsigned IDLE_NEED = 1,
  localparam int unsigned CW = $clog2(HOLD_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          active_i,
  input  logic          plain_i,
  output logic          restart_o,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned OW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] FULL_V    = CW'(HOLD_CYC);
  localparam logic [CW-1:0] ONE_V     = CW'(1);
  localparam logic [OW-1:0] ONES_LAST = OW'(IDLE_BITS - 1);

  logic [OW-1:0] ones_q;
  logic [CW-1:0] cnt_q;
  logic          idle_hit;

  assign idle_hit = active_i && plain_i && (ones_q == ONES_LAST);
  assign expire_o = active_i && !restart_o && (cnt_q == ONE_V);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ones_q <= '0;
    else if (!active_i || !plain_i) ones_q <= '0;
    else if (idle_hit)              ones_q <= '0;
    else                            ones_q <= ones_q + 1'b1;
  end

  generate
    if (IDLE_NEED == 1) begin : g_single
      assign restart_o = idle_hit;
    end else begin : g_multi
      localparam int unsigned NW = $clog2(IDLE_NEED + 1);
      localparam logic [NW-1:0] OBS_LAST = NW'(IDLE_NEED - 1);
      logic [NW-1:0] obs_q;

      assign restart_o = idle_hit && (obs_q == OBS_LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        obs_q <= '0;
        else if (!active_i) obs_q <= '0;
        else if (restart_o) obs_q <= '0;
        else if (idle_hit)  obs_q <= obs_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= start_i ? FULL_V : '0;
    else if (restart_o) cnt_q <= FULL_V;
    else                cnt_q <= cnt_q - ONE_V;
  end
endmodule

// File: rtl/descram_lock.sv
module descram_lock #(
  parameter int unsigned ACQ_RUN   = 40,
  parameter int unsigned HOLD_CYC  = 90250,
  parameter int unsigned IDLE_BITS = 10,
  parameter int unsigned IDLE_NEED = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  output logic data_o,
  output logic valid_o,
  output logic locked_o
);
  import descram_pkg::*;

  localparam int unsigned RW = $clog2(ACQ_RUN);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  lock_st_e      st_q;
  logic          hunt;
  logic          key;
  logic          plain;
  logic          lock_hit;
  logic          restart;
  logic          expire;
  logic [RW-1:0] run_cnt;
  logic [CW-1:0] hold_cnt;
  logic          data_q;
  logic          valid_q;

  assign hunt  = (st_q == ST_HUNT);
  assign plain = rx_bit_i ^ key;

  descram_lfsr #(
    .W      (LFSR_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO)
  ) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_rx_i (hunt),
    .rx_bit_i  (rx_bit_i),
    .key_o     (key)
  );

  // idle assumption: plain bit 1 means received bit is the inverted key
  descram_acq #(
    .RUN  (ACQ_RUN),
    .SEED (LFSR_W)
  ) u_acq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hunt_i     (hunt),
    .match_i    (plain),
    .lock_hit_o (lock_hit),
    .run_o      (run_cnt)
  );

  descram_hold #(
    .HOLD_CYC  (HOLD_CYC),
    .IDLE_BITS (IDLE_BITS),
    .IDLE_NEED (IDLE_NEED)
  ) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (lock_hit),
    .active_i  (!hunt),
    .plain_i   (plain),
    .restart_o (restart),
    .expire_o  (expire),
    .cnt_o     (hold_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      data_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= !hunt && plain;
      valid_q <= !hunt;
      case (st_q)
        ST_HUNT: if (lock_hit) st_q <= ST_LOCK;
        ST_LOCK: if (expire)   st_q <= ST_HUNT;
        default:               st_q <= ST_HUNT;
      endcase
    end
  end

  assign data_o   = data_q;
  assign valid_o  = valid_q;
  assign locked_o = (st_q == ST_LOCK);
endmodule

// File: rtl/descram_lock_chk.sv
module descram_lock_chk #(
  parameter int unsigned ACQ_RUN  = 40,
  parameter int unsigned HOLD_CYC = 90250
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        data_o,
  input logic        valid_o,
  input logic        locked_o,
  input logic        restart_i,
  input logic [31:0] run_cnt_i,
  input logic [31:0] hold_cnt_i
);
  a_r2_lock_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(run_cnt_i) == ACQ_RUN - 1));

  a_r5_valid_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(locked_o));

  a_r5_quiet_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !data_o);

  a_r6_timer_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (hold_cnt_i != 0));

  a_r6_drop_at_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> ($past(hold_cnt_i) == 1));

  a_r7_reload_by_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o) && hold_cnt_i == HOLD_CYC) |-> $past(restart_i));

  a_r8_fresh_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> (run_cnt_i == 0));

  a_r9_full_on_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> (hold_cnt_i == HOLD_CYC));
endmodule

bind descram_lock descram_lock_chk #(
  .ACQ_RUN  (ACQ_RUN),
  .HOLD_CYC (HOLD_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .locked_o   (locked_o),
  .restart_i  (restart),
  .run_cnt_i  (32'(run_cnt)),
  .hold_cnt_i (32'(hold_cnt))
);

// File: tb/descram_lock_tb_top.sv
module descram_lock_tb_top;
  localparam int unsigned ACQ  = 40;
  localparam int unsigned HOLD = 150;
  localparam int unsigned IBIT = 10;
  localparam int unsigned NEED = 2;

  typedef struct packed {
    logic valid;
    logic data;
    logic locked;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0;
  logic data_o, valid_o, locked_o;

  int checks = 0;
  int errors = 0;

  exp_t  exp_q[$];
  string tag_q[$];
  string cur_req = "R1";

  // far-end scrambler and requirement model
  logic [10:0] far_s = 11'h5A3;
  logic [10:0] m_h   = '0;
  logic        m_l   = 1'b0;
  int          m_run = 0;
  int          m_t   = 0;
  int          m_ones = 0;
  int          m_obs  = 0;
  int unsigned lcg   = 32'h1234_5678;

  always #2 clk = ~clk;

  descram_lock #(
    .ACQ_RUN   (ACQ),
    .HOLD_CYC  (HOLD),
    .IDLE_BITS (IBIT),
    .IDLE_NEED (NEED)
  ) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .rx_bit_i (rx_bit),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .locked_o (locked_o)
  );

  function automatic logic rnd_bit();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[16];
  endfunction

  task automatic send(input logic p, input logic corrupt);
    logic k, r, mk, d, rs;
    exp_t e;
    @(negedge clk);
    k     = far_s[10] ^ far_s[8];
    far_s = {far_s[9:0], k};
    r     = p ^ k ^ corrupt;
    rx_bit = r;
    e.valid = m_l;
    e.data  = m_l ? p : 1'b0;
    mk = m_h[10] ^ m_h[8];
    if (!m_l) begin
      m_h = {m_h[9:0], ~r};
      if (m_run < 11) m_run++;
      else if (~r == mk) begin
        if (m_run == ACQ - 1) begin
          m_l = 1'b1; m_t = HOLD; m_run = 0; m_ones = 0; m_obs = 0;
        end else m_run++;
      end else m_run = 0;
    end else begin
      m_h = {m_h[9:0], mk};
      d  = p;
      rs = 1'b0;
      if (d) begin
        if (m_ones == IBIT - 1) begin
          m_ones = 0;
          if (m_obs == NEED - 1) begin m_obs = 0; rs = 1'b1; end
          else m_obs++;
        end else m_ones++;
      end else m_ones = 0;
      if (rs) m_t = HOLD;
      else if (m_t == 1) begin m_l = 1'b0; m_run = 0; end
      else m_t--;
    end
    e.locked = m_l;
    exp_q.push_back(e);
    tag_q.push_back(cur_req);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    exp_t  e;
    string t;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (valid_o !== e.valid || data_o !== e.data || locked_o !== e.locked) begin
        errors++;
        $display("FAIL %s v/d/l actual %0b%0b%0b expected %0b%0b%0b", t,
                 valid_o, data_o, locked_o, e.valid, e.data, e.locked);
      end
    end
  end

  task automatic expect_locked(input logic v, input string req);
    @(posedge clk);
    #1;
    checks++;
    if (locked_o !== v) begin
      errors++;
      $display("FAIL %s locked_o actual %0b expected %0b", req, locked_o, v);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (data_o !== 1'b0 || valid_o !== 1'b0 || locked_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset d/v/l actual %0b%0b%0b expected 000", data_o, valid_o, locked_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R3: garbage, partial idle, one corrupted bit, then 39 idle is not enough
    cur_req = "R3";
    for (int i = 0; i < 25; i++) send(rnd_bit(), 1'b0);
    for (int i = 0; i < 30; i++) send(1'b1, 1'b0);
    send(1'b1, 1'b1);
    for (int i = 0; i < 39; i++) send(1'b1, 1'b0);
    expect_locked(1'b0, "R3");
    // R2: 40th consistent bit grants lock
    cur_req = "R2";
    send(1'b1, 1'b0);
    expect_locked(1'b1, "R2");

    // R4: data with no ten-ones runs
    cur_req = "R4";
    for (int i = 0; i < 80; i++) send((i % 8 == 7) ? 1'b0 : rnd_bit(), 1'b0);

    // R7: two observations reload the timer on the 20th one
    cur_req = "R7";
    send(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) send(1'b1, 1'b0);
    for (int j = 0; j < 149; j++) send(1'(j % 2), 1'b0);
    expect_locked(1'b1, "R7");
    cur_req = "R6";
    send(1'b1, 1'b0);
    expect_locked(1'b0, "R6");

    // R8: fresh reacquisition
    cur_req = "R8";
    for (int i = 0; i < 39; i++) send(1'b1, 1'b0);
    expect_locked(1'b0, "R8");
    send(1'b1, 1'b0);
    expect_locked(1'b1, "R8");

    // R7/R9: one observation plus a broken run do not reload; expiry counted from lock
    cur_req = "R7";
    for (int i = 0; i < 10; i++) send(1'b1, 1'b0);
    send(1'b0, 1'b0);
    for (int i = 0; i < 9; i++) send(1'b1, 1'b0);
    send(1'b0, 1'b0);
    for (int j = 0; j < 128; j++) send(1'(j % 2), 1'b0);
    expect_locked(1'b1, "R9");
    cur_req = "R9";
    send(1'b0, 1'b0);
    expect_locked(1'b0, "R9");

    // R5: no output while hunting
    cur_req = "R5";
    for (int i = 0; i < 30; i++) send(rnd_bit(), 1'b0);
    repeat (4) @(posedge clk);
    #1;
    summary();
    $finish;
  end
endmodule